// File: doc/BRIEF.md
# CPU External Interrupt Acceptance Unit

This block sits beside a small 32-bit processor core. It decides when an external interrupt is taken. Thirty-two level-sensitive request lines feed a sticky pending register. A request that has been seen stays recorded until software clears it, even after the line goes low. A software-written mask selects which pending requests may interrupt the core. A global enable bit gates the whole decision.

The check runs only at instruction boundaries, which the core marks with a retire strobe. On a retire cycle with the enable bit set and at least one pending request unmasked, the unit pulses its redirect outputs in that same cycle. It gives the core the handler address, which is the exception base plus the fixed interrupt slot offset 0xC0 (slot 6 of 32 bytes). It also gives a write strobe and data that put the interrupted PC into the return-address register. On the next clock the enable register changes to the entry encoding 0x2: the global enable is cleared and the saved-enable bit is set. A request that cannot be taken yet stays pending. It is tried again at every later boundary, so enabling or unmasking later still lets it through.

Top module: `irq_accept_unit`

## Requirements
- R1: A high level on request line n at a rising clock edge sets pending bit n. The bit is visible in a pending-register read from the next cycle on.
- R2: A low level on a request line never clears its pending bit. Only a software clear does.
- R3: A control write to the pending register clears every bit where the write data holds 1. If the matching request line is high at that same edge, the bit stays set.
- R4: The redirect and return-address strobes are high in a cycle exactly when retire is high, enable bit 0 is 1, and mask AND pending is nonzero. Otherwise both are low.
- R5: In an accepting cycle the return-address data equals the current PC input.
- R6: In an accepting cycle the redirect PC equals the base register plus 0xC0. Bits 7:0 of a base write are dropped, and those bits read back as zero.
- R7: After an accepting cycle the enable register reads 0x2. Entry takes priority over a control write to the enable register at the same edge.
- R8: A request that stays pending while masked or disabled causes no redirect. It is taken at the first retire after both the enable bit and its mask bit are set.
- R9: After reset, the pending, mask, enable and base registers all read zero, and no redirect occurs.
- R10: The register select encoding is 0 for pending, 1 for mask, 2 for enable and 3 for base. Only bits 1:0 of the enable register are stored, and its other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 32 | Level interrupt requests, bit n is request n |
| csrWe | input | 1 | Control register write strobe |
| csrSel | input | 2 | Control register select (0 pending, 1 mask, 2 enable, 3 base) |
| csrWdata | input | 32 | Control register write data |
| csrRdata | output | 32 | Control register read data, combinational from the select |
| retire | input | 1 | Instruction boundary strobe |
| curPc | input | 32 | PC of the interrupted point |
| redirect | output | 1 | Take-interrupt pulse, same cycle as retire |
| redirectPc | output | 32 | Handler address |
| raWe | output | 1 | Return-address register write enable |
| raData | output | 32 | Return address to write |

## Verification
A pending bit that is lost or set falsely shows up in two ways. A read of the pending register gives a wrong value on the next cycle. A redirect is also taken or missed at the next retire once the bit is unmasked and enabled. A wrong enable state shows within one retire: an interrupt is taken twice in a row, or a waiting request is never taken after software enables it. A wrong base or offset appears at once on the redirect PC during the accepting cycle. The bench therefore compares the strobes on every cycle and the address outputs on every accept, and it reads back all four registers around each event.

// File: rtl/irqu_pkg.sv
package irqu_pkg;
  typedef enum logic [1:0] {
    CSR_PEND = 2'd0,
    CSR_MASK = 2'd1,
    CSR_EN   = 2'd2,
    CSR_BASE = 2'd3
  } csrSel_e;

  typedef struct packed {
    logic take;
    logic wrPend;
    logic wrMask;
    logic wrEn;
    logic wrBase;
  } irqStrobes_t;
endpackage

// File: rtl/irqu_ctrl.sv
module irqu_ctrl
  import irqu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrWe,
  input  logic [1:0]  csrSel,
  input  logic        retire,
  input  logic        gie,
  input  logic        hit,
  output irqStrobes_t strb
);
  always_comb begin
    strb.take   = retire && gie && hit;
    strb.wrPend = csrWe && (csrSel == CSR_PEND);
    strb.wrMask = csrWe && (csrSel == CSR_MASK);
    strb.wrEn   = csrWe && (csrSel == CSR_EN);
    strb.wrBase = csrWe && (csrSel == CSR_BASE);
  end

  // R4
  take_needs_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gie |-> !strb.take);

  // R7
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> !strb.take);
endmodule

// File: rtl/irqu_dpath.sv
module irqu_dpath
  import irqu_pkg::*;
#(
  parameter int NumIrq    = 32,
  parameter int XLen      = 32,
  parameter int VecId     = 6,
  parameter int SlotBytes = 32,
  parameter int BaseLow   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobes_t       strb,
  input  logic [NumIrq-1:0] irqLines,
  input  logic [1:0]        csrSel,
  input  logic [XLen-1:0]   csrWdata,
  output logic [XLen-1:0]   csrRdata,
  input  logic [XLen-1:0]   curPc,
  output logic              gie,
  output logic              hit,
  output logic [XLen-1:0]   redirectPc,
  output logic [XLen-1:0]   raData
);
  localparam int VecOff = VecId * SlotBytes;

  logic [NumIrq-1:0]       pendQ, maskQ, pendClr;
  logic [1:0]              ienQ;
  logic [XLen-1:BaseLow]   baseQ;

  assign pendClr = strb.wrPend ? csrWdata[NumIrq-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
      ienQ  <= 2'b00;
      baseQ <= '0;
    end else begin
      pendQ <= (pendQ & ~pendClr) | irqLines;
      if (strb.wrMask) maskQ <= csrWdata[NumIrq-1:0];
      if (strb.take)      ienQ <= 2'b10;
      else if (strb.wrEn) ienQ <= csrWdata[1:0];
      if (strb.wrBase) baseQ <= csrWdata[XLen-1:BaseLow];
    end
  end

  assign gie        = ienQ[0];
  assign hit        = |(pendQ & maskQ);
  assign redirectPc = {baseQ, {BaseLow{1'b0}}} + XLen'(VecOff);
  assign raData     = curPc;

  always_comb begin
    unique case (csrSel_e'(csrSel))
      CSR_PEND: csrRdata = XLen'(pendQ);
      CSR_MASK: csrRdata = XLen'(maskQ);
      CSR_EN:   csrRdata = XLen'(ienQ);
      default:  csrRdata = {baseQ, {BaseLow{1'b0}}};
    endcase
  end

  // R1
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(irqLines)) & ~pendQ) == '0));

  // R2
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPend |=> ((($past(pendQ)) & ~pendQ) == '0));

  // R7
  entry_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> (ienQ == 2'b10));
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irqu_pkg::*;
#(
  parameter int NumIrq = 32,
  parameter int XLen   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumIrq-1:0] irqLines,
  input  logic              csrWe,
  input  logic [1:0]        csrSel,
  input  logic [XLen-1:0]   csrWdata,
  output logic [XLen-1:0]   csrRdata,
  input  logic              retire,
  input  logic [XLen-1:0]   curPc,
  output logic              redirect,
  output logic [XLen-1:0]   redirectPc,
  output logic              raWe,
  output logic [XLen-1:0]   raData
);
  irqStrobes_t strb;
  logic gie, hit;

  irqu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrSel(csrSel),
    .retire(retire), .gie(gie), .hit(hit), .strb(strb)
  );

  irqu_dpath #(.NumIrq(NumIrq), .XLen(XLen)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .irqLines(irqLines),
    .csrSel(csrSel), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .curPc(curPc), .gie(gie), .hit(hit),
    .redirectPc(redirectPc), .raData(raData)
  );

  assign redirect = strb.take;
  assign raWe     = strb.take;
endmodule

// File: tb/sim_irq_accept_unit.sv
`timescale 1ns/1ps
module sim_irq_accept_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqLines = '0;
  logic        csrWe = 1'b0;
  logic [1:0]  csrSel = 2'd0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata;
  logic        retire = 1'b0;
  logic [31:0] curPc = '0;
  logic        redirect, raWe;
  logic [31:0] redirectPc, raData;

  always #2.5 clk = ~clk;

  irq_accept_unit u0 (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .csrWe(csrWe),
    .csrSel(csrSel), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .retire(retire), .curPc(curPc), .redirect(redirect),
    .redirectPc(redirectPc), .raWe(raWe), .raData(raData)
  );

  typedef struct {
    bit          take;
    logic [31:0] ra;
    logic [31:0] tgt;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int tests = 0;
  int fails = 0;

  // Bench model of the register state, from the requirements
  logic [31:0] mPend = '0, mMask = '0, mBase = '0;
  logic [1:0]  mIen = '0;

  function automatic logic [31:0] modelRead(input logic [1:0] s);
    case (s)
      2'd0: return mPend;
      2'd1: return mMask;
      2'd2: return {30'd0, mIen};
      default: return mBase;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; optional read check against the model
  task automatic cyc(input logic [31:0] irq, input bit we, input logic [1:0] sel,
                     input logic [31:0] wd, input bit ret, input logic [31:0] pc,
                     input bit doRead, input string tag);
    expItem_t it;
    bit tk;
    logic [31:0] expRd;
    irqLines = irq; csrWe = we; csrSel = sel; csrWdata = wd;
    retire = ret; curPc = pc;
    tk = ret && mIen[0] && ((mMask & mPend) != 0);
    it.take = tk; it.ra = pc; it.tgt = mBase + 32'h0000_00C0; it.tag = tag;
    expQ.push_back(it);
    expRd = modelRead(sel);
    @(negedge clk);
    if (doRead) chk(tag, csrRdata, expRd);
    @(posedge clk);
    mPend = (mPend & ~((we && sel == 2'd0) ? wd : 32'd0)) | irq;
    if (we && sel == 2'd1) mMask = wd;
    if (tk) mIen = 2'b10;
    else if (we && sel == 2'd2) mIen = wd[1:0];
    if (we && sel == 2'd3) mBase = wd & 32'hFFFF_FF00;
    #1;
  endtask

  task automatic rd(input logic [31:0] irq, input logic [1:0] sel, input string tag);
    cyc(irq, 1'b0, sel, 32'd0, 1'b0, 32'd0, 1'b1, tag);
  endtask

  task automatic wr(input logic [31:0] irq, input logic [1:0] sel, input logic [31:0] wd);
    cyc(irq, 1'b1, sel, wd, 1'b0, 32'd0, 1'b0, "R10");
  endtask

  task automatic ret(input logic [31:0] irq, input logic [31:0] pc, input string tag);
    cyc(irq, 1'b0, 2'd0, 32'd0, 1'b1, pc, 1'b0, tag);
  endtask

  // Monitor: pops one expectation per cycle
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        chk({e.tag, " R4 redirect"}, {31'd0, redirect}, {31'd0, e.take});
        chk({e.tag, " R4 raWe"}, {31'd0, raWe}, {31'd0, e.take});
        if (e.take) begin
          chk({e.tag, " R5 raData"}, raData, e.ra);
          chk({e.tag, " R6 redirectPc"}, redirectPc, e.tgt);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R9 reset state
    rd(0, 2'd0, "R9"); rd(0, 2'd1, "R9"); rd(0, 2'd2, "R9"); rd(0, 2'd3, "R9");
    ret(0, 32'h0000_0040, "R9");
    // R6 / R10 base low bits dropped; mask write
    wr(0, 2'd3, 32'h1234_56FF);
    rd(0, 2'd3, "R6");
    wr(0, 2'd1, 32'h0000_0011);
    rd(0, 2'd1, "R10");
    // R1 / R2 one-cycle pulse on line 4, then low
    cyc(32'h10, 1'b0, 2'd0, 0, 1'b0, 0, 1'b0, "R1");
    rd(0, 2'd0, "R1");
    rd(0, 2'd0, "R2");
    // R8 disabled: no take
    ret(0, 32'h0000_0100, "R8");
    // R10 enable: upper bits not stored
    wr(0, 2'd2, 32'hFFFF_FFFD);
    rd(0, 2'd2, "R10");
    wr(0, 2'd2, 32'h0000_0001);
    ret(0, 32'h0000_0104, "R8");
    rd(0, 2'd2, "R7");
    ret(0, 32'h0000_0108, "R7");
    // R3 clear, then clear against a high line
    wr(0, 2'd0, 32'h0000_0010);
    rd(0, 2'd0, "R3");
    cyc(32'h1, 1'b1, 2'd0, 32'h1, 1'b0, 0, 1'b0, "R3");
    rd(0, 2'd0, "R3");
    wr(0, 2'd0, 32'h1);
    rd(0, 2'd0, "R3");
    // R4 masked request does not interrupt
    cyc(32'h20, 1'b0, 2'd0, 0, 1'b0, 0, 1'b0, "R4");
    wr(0, 2'd2, 32'h1);
    ret(0, 32'h0000_0200, "R4");
    // R8 unmask later, then taken; R7 entry beats enable write
    wr(0, 2'd1, 32'h0000_0020);
    cyc(0, 1'b1, 2'd2, 32'h1, 1'b1, 32'h0000_0204, 1'b0, "R7");
    rd(0, 2'd2, "R7");
    // R8 line 31 held high while disabled, then enabled
    wr(32'h8000_0000, 2'd0, 32'h20);
    wr(32'h8000_0000, 2'd1, 32'h8000_0000);
    wr(32'h8000_0000, 2'd3, 32'hABCD_E000);
    ret(32'h8000_0000, 32'h0000_0300, "R8");
    ret(32'h8000_0000, 32'h0000_0304, "R8");
    wr(32'h8000_0000, 2'd2, 32'h3);
    ret(32'h8000_0000, 32'h0000_0308, "R8");
    ret(0, 32'h0000_030C, "R8");
    rd(0, 2'd0, "R2");
    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule